// File: doc/BRIEF.md
# Load/Store Offset Splitter for a Shared Execute-Memory Stage

This block sits in the decode stage of a four-stage pipeline: fetch, decode, execute-memory, writeback. In that pipeline the data memory takes its address straight from the rs1 operand, so the ALU and the memory can share a single stage. A load or store with a zero offset needs no ALU work and goes through unchanged.

A load or store with a nonzero offset is split in hardware into two pipeline operations. The first is an address add, `addi` of rs1 plus the offset. It writes no register and touches no memory. The second is a copy of the original access with its offset cleared. The copy takes its address from the forwarded add result rather than from the register file, so rs1 keeps its architectural value.

The block owns the decode slot and the execute-memory control register. It holds the PC for one cycle while the copy is injected into decode. A redirect from an older taken branch drops both the half-generated add and the pending copy.

Top module: `memsplit_decode`

## Requirements
- R1: While reset is held and after it is released, the execute-memory slot is empty: emValid, emRegWrite, emMemRead and emMemWrite read 0. The decode slot holds no injected copy: decInjected reads 0.
- R2: A load (opcode 0000011) or store (opcode 0100011) with a zero offset, and any other opcode, moves into execute-memory one advancing cycle after it enters decode. It keeps its opcode, registers and offset, pcEnable stays 1, and emSplitAdd and emAddrFwd read 0.
- R3: While a load or store with a nonzero offset that is not an injected copy sits in decode, pcEnable is 0. The next fetched instruction is therefore held back one cycle.
- R4: The split instruction leaves decode as an address add. The execute-memory slot shows opcode 0010011, funct3 000, the original rs1 and the original offset, with emSplitAdd set to 1.
- R5: The address add has no architectural effect. Its emRegWrite, emMemRead and emMemWrite read 0, and its emRd reads 0.
- R6: While the address add is in execute-memory, decode holds the injected copy (decInjected = 1). On the next advance the copy enters execute-memory with the original opcode, funct3, rd and rs2, an offset of 0, and emAddrFwd = 1. A load copy has emMemRead and emRegWrite set to 1; a store copy has emMemWrite set to 1 and emRegWrite set to 0.
- R7: An injected copy is never split again: while it is in decode, pcEnable is 1 whenever advance is 1.
- R8: The instruction after a split access reaches execute-memory exactly one cycle later than it would without the split. Two split accesses in a row each expand to an add followed by their own copy, in program order.
- R9: A redirect in a cycle when the split instruction is in decode empties both slots. pcEnable is 1 during that cycle. No address add and no copy appear afterwards.
- R10: While advance is 0 and redirect is 0, pcEnable is 0 and the execute-memory slot and the decode slot keep their contents. A pending split resumes when advance returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline may move this cycle |
| redirect | input | 1 | Older taken branch; flush decode and execute-memory |
| fetchValid | input | 1 | Fetched instruction is valid |
| fetchOpcode | input | 7 | Fetched opcode |
| fetchFunct3 | input | 3 | Fetched funct3 |
| fetchRs1 | input | 5 | Fetched rs1 index |
| fetchRs2 | input | 5 | Fetched rs2 index |
| fetchRd | input | 5 | Fetched rd index |
| fetchImm | input | 32 | Fetched sign-extended immediate |
| pcEnable | output | 1 | PC and fetch may move on |
| decInjected | output | 1 | Decode slot holds an injected zero-offset copy |
| emValid | output | 1 | Execute-memory slot valid |
| emOpcode | output | 7 | Opcode entering execute-memory |
| emFunct3 | output | 3 | funct3 entering execute-memory |
| emRs1 | output | 5 | rs1 index entering execute-memory |
| emRs2 | output | 5 | rs2 index entering execute-memory |
| emRd | output | 5 | rd index entering execute-memory |
| emImm | output | 32 | Immediate entering execute-memory |
| emRegWrite | output | 1 | Register write enable |
| emMemRead | output | 1 | Data memory read enable |
| emMemWrite | output | 1 | Data memory write enable |
| emSplitAdd | output | 1 | Slot holds a generated address add |
| emAddrFwd | output | 1 | Take the memory address from the forwarded add result |

## Verification
The bench targets four corner cases.

- **Re-split of the copy.** The injected copy still carries the load or store opcode, so a design that splits it again would stall forever and emit an endless chain of address adds.
- **Leaking address add.** An add that kept its register write would corrupt rs1 or rd. A copy that read rs1 from the register file instead of the forwarded sum would access the unoffset address.
- **Back-to-back splits.** These check that the held fetch instruction is not lost or duplicated when the PC stalls.
- **Redirect and held advance.** A redirect during a pending split, and a period with advance low, check that a stale copy does not survive a flush and that a stall does not consume the injection.

// File: rtl/memsplit_pkg.sv
package memsplit_pkg;
  parameter int XLEN   = 32;
  parameter int REG_AW = 5;
  parameter int OPC_W  = 7;
  parameter int F3_W   = 3;

  typedef logic [OPC_W-1:0]  opcode_t;
  typedef logic [F3_W-1:0]   funct3_t;
  typedef logic [REG_AW-1:0] regIdx_t;
  typedef logic [XLEN-1:0]   word_t;

  localparam opcode_t OPC_LOAD   = 7'b0000011;
  localparam opcode_t OPC_STORE  = 7'b0100011;
  localparam opcode_t OPC_OPIMM  = 7'b0010011;
  localparam opcode_t OPC_OP     = 7'b0110011;
  localparam opcode_t OPC_LUI    = 7'b0110111;
  localparam opcode_t OPC_AUIPC  = 7'b0010111;
  localparam opcode_t OPC_JAL    = 7'b1101111;
  localparam opcode_t OPC_JALR   = 7'b1100111;
  localparam funct3_t F3_ADD     = '0;

  // Instruction waiting in decode
  typedef struct packed {
    logic    valid;
    opcode_t opcode;
    funct3_t funct3;
    regIdx_t rs1;
    regIdx_t rs2;
    regIdx_t rd;
    word_t   imm;
    logic    split;   // already expanded, never split again
  } decSlot_t;

  // Control and operands heading into execute-memory
  typedef struct packed {
    logic    valid;
    opcode_t opcode;
    funct3_t funct3;
    regIdx_t rs1;
    regIdx_t rs2;
    regIdx_t rd;
    word_t   imm;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    splitAdd;
    logic    addrFwd;
  } emSlot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic step;
    logic splitNow;
  } strobe_t;

  function automatic logic isMemOp(opcode_t op);
    return (op == OPC_LOAD) || (op == OPC_STORE);
  endfunction

  function automatic logic writesRd(opcode_t op);
    return (op == OPC_LOAD) || (op == OPC_OPIMM) || (op == OPC_OP) ||
           (op == OPC_LUI) || (op == OPC_AUIPC) || (op == OPC_JAL) ||
           (op == OPC_JALR);
  endfunction
endpackage

// File: rtl/memsplit_ctrl.sv
module memsplit_ctrl
  import memsplit_pkg::*;
(
  input  logic     advance,
  input  logic     redirect,
  input  decSlot_t decView,
  output strobe_t  strobes,
  output logic     pcEnable
);
  logic needSplit;
  logic immNonZero;

  always_comb begin
    immNonZero = |decView.imm;
    needSplit  = decView.valid && isMemOp(decView.opcode) &&
                 immNonZero && !decView.split;

    strobes.flush    = redirect;
    strobes.step     = advance && !redirect;
    strobes.splitNow = needSplit && !redirect;

    // redirect lets the PC take its target; a split holds the fetch
    pcEnable = redirect || (advance && !needSplit);
  end
endmodule

// File: rtl/memsplit_datapath.sv
module memsplit_datapath
  import memsplit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  strobe_t  strobes,
  input  decSlot_t fetchSlot,
  output decSlot_t decView,
  output emSlot_t  emView
);
  decSlot_t decQ;
  emSlot_t  emQ;
  emSlot_t  emNext;
  decSlot_t injSlot;

  // zero-offset copy of the access now in decode
  always_comb begin
    injSlot       = decQ;
    injSlot.imm   = '0;
    injSlot.split = 1'b1;
  end

  // translate the decode slot into execute-memory control
  always_comb begin
    emNext.valid  = decQ.valid;
    emNext.funct3 = decQ.funct3;
    emNext.rs1    = decQ.rs1;
    emNext.rs2    = decQ.rs2;
    emNext.imm    = decQ.imm;
    if (strobes.splitNow) begin
      emNext.opcode   = OPC_OPIMM;
      emNext.funct3   = F3_ADD;
      emNext.rd       = '0;
      emNext.regWrite = 1'b0;
      emNext.memRead  = 1'b0;
      emNext.memWrite = 1'b0;
      emNext.splitAdd = 1'b1;
      emNext.addrFwd  = 1'b0;
    end else begin
      emNext.opcode   = decQ.opcode;
      emNext.rd       = decQ.rd;
      emNext.regWrite = decQ.valid && writesRd(decQ.opcode);
      emNext.memRead  = decQ.valid && (decQ.opcode == OPC_LOAD);
      emNext.memWrite = decQ.valid && (decQ.opcode == OPC_STORE);
      emNext.splitAdd = 1'b0;
      emNext.addrFwd  = decQ.valid && decQ.split && isMemOp(decQ.opcode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decQ <= '0;
      emQ  <= '0;
    end else if (strobes.flush) begin
      decQ <= '0;
      emQ  <= '0;
    end else if (strobes.step) begin
      emQ  <= emNext;
      decQ <= strobes.splitNow ? injSlot : fetchSlot;
    end
  end

  assign decView = decQ;
  assign emView  = emQ;
endmodule

// File: rtl/memsplit_decode.sv
module memsplit_decode
  import memsplit_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic                redirect,
  input  logic                fetchValid,
  input  logic [OPC_W-1:0]    fetchOpcode,
  input  logic [F3_W-1:0]     fetchFunct3,
  input  logic [REG_AW-1:0]   fetchRs1,
  input  logic [REG_AW-1:0]   fetchRs2,
  input  logic [REG_AW-1:0]   fetchRd,
  input  logic [XLEN-1:0]     fetchImm,
  output logic                pcEnable,
  output logic                decInjected,
  output logic                emValid,
  output logic [OPC_W-1:0]    emOpcode,
  output logic [F3_W-1:0]     emFunct3,
  output logic [REG_AW-1:0]   emRs1,
  output logic [REG_AW-1:0]   emRs2,
  output logic [REG_AW-1:0]   emRd,
  output logic [XLEN-1:0]     emImm,
  output logic                emRegWrite,
  output logic                emMemRead,
  output logic                emMemWrite,
  output logic                emSplitAdd,
  output logic                emAddrFwd
);
  decSlot_t fetchSlot;
  decSlot_t decView;
  emSlot_t  emView;
  strobe_t  strobes;

  always_comb begin
    fetchSlot.valid  = fetchValid;
    fetchSlot.opcode = fetchOpcode;
    fetchSlot.funct3 = fetchFunct3;
    fetchSlot.rs1    = fetchRs1;
    fetchSlot.rs2    = fetchRs2;
    fetchSlot.rd     = fetchRd;
    fetchSlot.imm    = fetchImm;
    fetchSlot.split  = 1'b0;
  end

  memsplit_ctrl u_ctrl (
    .advance (advance),
    .redirect(redirect),
    .decView (decView),
    .strobes (strobes),
    .pcEnable(pcEnable)
  );

  memsplit_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .fetchSlot(fetchSlot),
    .decView  (decView),
    .emView   (emView)
  );

  assign decInjected = decView.valid && decView.split;
  assign emValid     = emView.valid;
  assign emOpcode    = emView.opcode;
  assign emFunct3    = emView.funct3;
  assign emRs1       = emView.rs1;
  assign emRs2       = emView.rs2;
  assign emRd        = emView.rd;
  assign emImm       = emView.imm;
  assign emRegWrite  = emView.regWrite;
  assign emMemRead   = emView.memRead;
  assign emMemWrite  = emView.memWrite;
  assign emSplitAdd  = emView.splitAdd;
  assign emAddrFwd   = emView.addrFwd;
endmodule

// File: rtl/memsplit_checker.sv
module memsplit_checker
  import memsplit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              advance,
  input logic              redirect,
  input logic              pcEnable,
  input logic              decInjected,
  input logic              emValid,
  input logic [REG_AW-1:0] emRd,
  input logic [XLEN-1:0]   emImm,
  input logic              emRegWrite,
  input logic              emMemRead,
  input logic              emMemWrite,
  input logic              emSplitAdd,
  input logic              emAddrFwd
);
  assert_stall_yields_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !redirect && !pcEnable) |=> (emValid && emSplitAdd));

  assert_add_is_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emValid && emSplitAdd) |-> (!emRegWrite && !emMemRead && !emMemWrite));

  assert_copy_follows_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emValid && emSplitAdd && advance && !redirect) |=>
      (emValid && emAddrFwd && !emSplitAdd && emImm == '0));

  assert_copy_not_resplit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decInjected |-> (pcEnable == (advance || redirect)));

  assert_redirect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!emValid && !decInjected));

  assert_hold_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !redirect) |=>
      ($stable(emValid) && $stable(emRd) && $stable(emImm) && $stable(decInjected)));
endmodule

bind memsplit_decode memsplit_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .redirect   (redirect),
  .pcEnable   (pcEnable),
  .decInjected(decInjected),
  .emValid    (emValid),
  .emRd       (emRd),
  .emImm      (emImm),
  .emRegWrite (emRegWrite),
  .emMemRead  (emMemRead),
  .emMemWrite (emMemWrite),
  .emSplitAdd (emSplitAdd),
  .emAddrFwd  (emAddrFwd)
);

// File: tb/memsplit_decode_tb.sv
module memsplit_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] LD = 7'b0000011;
  localparam logic [6:0] ST = 7'b0100011;
  localparam logic [6:0] AI = 7'b0010011;
  localparam logic [6:0] RR = 7'b0110011;

  logic clk = 1'b0;
  logic rst_n, advance, redirect, fetchValid;
  logic [6:0] fetchOpcode;
  logic [2:0] fetchFunct3;
  logic [4:0] fetchRs1, fetchRs2, fetchRd;
  logic [31:0] fetchImm;
  logic pcEnable, decInjected, emValid;
  logic [6:0] emOpcode;
  logic [2:0] emFunct3;
  logic [4:0] emRs1, emRs2, emRd;
  logic [31:0] emImm;
  logic emRegWrite, emMemRead, emMemWrite, emSplitAdd, emAddrFwd;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memsplit_decode u_dut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic fetch(logic v, logic [6:0] op, logic [2:0] f3, logic [4:0] r1,
                       logic [4:0] r2, logic [4:0] rd, logic [31:0] imm);
    fetchValid = v; fetchOpcode = op; fetchFunct3 = f3;
    fetchRs1 = r1; fetchRs2 = r2; fetchRd = rd; fetchImm = imm;
  endtask

  task automatic idle();
    fetch(1'b0, '0, '0, '0, '0, '0, '0);
  endtask

  task automatic drain();
    idle();
    step(); step(); step();
  endtask

  task automatic test_reset();
    rst_n = 1'b0; advance = 1'b1; redirect = 1'b0; idle();
    step(); step();
    check("R1", "emValid in reset", emValid, 0);
    check("R1", "emMemRead in reset", emMemRead, 0);
    rst_n = 1'b1;
    step();
    check("R1", "emValid after reset", emValid, 0);
    check("R1", "emRegWrite after reset", emRegWrite, 0);
    check("R1", "emMemWrite after reset", emMemWrite, 0);
    check("R1", "decInjected after reset", decInjected, 0);
  endtask

  task automatic test_passthrough();
    fetch(1'b1, LD, 3'd2, 5'd2, 5'd0, 5'd4, 32'd0);
    step();
    check("R2", "pcEnable zero-offset load", pcEnable, 1);
    fetch(1'b1, RR, 3'd0, 5'd1, 5'd3, 5'd9, 32'd0);
    step();
    check("R2", "pcEnable after zero-offset load", pcEnable, 1);
    check("R2", "emOpcode", emOpcode, LD);
    check("R2", "emMemRead", emMemRead, 1);
    check("R2", "emRs1", emRs1, 2);
    check("R2", "emImm", emImm, 0);
    check("R2", "emAddrFwd", emAddrFwd, 0);
    check("R2", "emSplitAdd", emSplitAdd, 0);
    idle();
    step();
    check("R2", "reg-reg opcode", emOpcode, RR);
    check("R2", "reg-reg rd", emRd, 9);
    check("R2", "reg-reg regWrite", emRegWrite, 1);
    drain();
  endtask

  task automatic test_load_split();
    fetch(1'b1, LD, 3'd2, 5'd3, 5'd0, 5'd5, 32'd8);
    step();
    check("R3", "pcEnable with offset load in decode", pcEnable, 0);
    fetch(1'b1, AI, 3'd0, 5'd1, 5'd0, 5'd7, 32'd4);
    step();
    check("R4", "add opcode", emOpcode, AI);
    check("R4", "add funct3", emFunct3, 0);
    check("R4", "add rs1", emRs1, 3);
    check("R4", "add imm", emImm, 8);
    check("R4", "add marker", emSplitAdd, 1);
    check("R5", "add regWrite", emRegWrite, 0);
    check("R5", "add memRead", emMemRead, 0);
    check("R5", "add rd", emRd, 0);
    check("R6", "copy in decode", decInjected, 1);
    check("R7", "pcEnable with copy in decode", pcEnable, 1);
    step();
    check("R6", "copy opcode", emOpcode, LD);
    check("R6", "copy rd", emRd, 5);
    check("R6", "copy imm", emImm, 0);
    check("R6", "copy memRead", emMemRead, 1);
    check("R6", "copy regWrite", emRegWrite, 1);
    check("R6", "copy addrFwd", emAddrFwd, 1);
    idle();
    step();
    check("R8", "follower opcode", emOpcode, AI);
    check("R8", "follower rd", emRd, 7);
    check("R8", "follower regWrite", emRegWrite, 1);
    drain();
  endtask

  task automatic test_store_split();
    fetch(1'b1, ST, 3'd2, 5'd6, 5'd11, 5'd0, 32'hFFFF_FFFC);
    step();
    check("R3", "pcEnable with offset store", pcEnable, 0);
    idle();
    step();
    check("R4", "store add imm", emImm, 32'hFFFF_FFFC);
    check("R5", "store add memWrite", emMemWrite, 0);
    check("R5", "store add regWrite", emRegWrite, 0);
    step();
    check("R6", "store copy memWrite", emMemWrite, 1);
    check("R6", "store copy regWrite", emRegWrite, 0);
    check("R6", "store copy rs2", emRs2, 11);
    check("R6", "store copy imm", emImm, 0);
    drain();
  endtask

  task automatic test_back_to_back();
    fetch(1'b1, LD, 3'd2, 5'd1, 5'd0, 5'd12, 32'd16);
    step();
    fetch(1'b1, LD, 3'd2, 5'd2, 5'd0, 5'd13, 32'd20);
    check("R8", "first stall", pcEnable, 0);
    step();
    check("R8", "first add imm", emImm, 16);
    step();
    check("R8", "first copy rd", emRd, 12);
    check("R8", "second stall", pcEnable, 0);
    idle();
    step();
    check("R8", "second add imm", emImm, 20);
    check("R8", "second add marker", emSplitAdd, 1);
    step();
    check("R8", "second copy rd", emRd, 13);
    check("R8", "second copy addrFwd", emAddrFwd, 1);
    drain();
  endtask

  task automatic test_redirect();
    fetch(1'b1, LD, 3'd2, 5'd4, 5'd0, 5'd14, 32'd12);
    step();
    idle();
    redirect = 1'b1;
    #1;
    check("R9", "pcEnable during redirect", pcEnable, 1);
    step();
    redirect = 1'b0;
    check("R9", "emValid after redirect", emValid, 0);
    check("R9", "decInjected after redirect", decInjected, 0);
    step();
    check("R9", "no add after redirect", emValid, 0);
    step();
    check("R9", "no copy after redirect", emValid, 0);
  endtask

  task automatic test_hold();
    fetch(1'b1, RR, 3'd0, 5'd1, 5'd2, 5'd21, 32'd0);
    step();
    fetch(1'b1, LD, 3'd2, 5'd8, 5'd0, 5'd22, 32'd24);
    step();
    idle();
    advance = 1'b0;
    #1;
    check("R10", "pcEnable while held", pcEnable, 0);
    step(); step();
    check("R10", "held emValid", emValid, 1);
    check("R10", "held emRd", emRd, 21);
    check("R10", "held decInjected", decInjected, 0);
    advance = 1'b1;
    step();
    check("R10", "resume add", emSplitAdd, 1);
    check("R10", "resume add imm", emImm, 24);
    step();
    check("R10", "resume copy rd", emRd, 22);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_passthrough();
    test_load_split();
    test_store_split();
    test_back_to_back();
    test_redirect();
    test_hold();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule